// File: doc/BRIEF.md
# Variable Refresh Vertical Timing Controller

This block produces the vertical timing of one display pipe. A line-tick input marks the end of every scanline, and the block keeps a line counter against a programmed active height. Its outputs are a vertical-blanking flag, a one-cycle frame-start pulse and a one-cycle latch pulse that tells double-buffered settings elsewhere in the pipe when to take their new values.

When variable refresh is off, the block is a plain vertical counter whose frame length comes from the minimum-total register. When variable refresh is on, the block holds the frame in blanking until one of two things happens. Software may post a push request, and the exit then starts as soon as the flip-line bound allows. If no push arrives, the exit starts at the maximum decision boundary. The exit lasts a programmable number of lines, made up of a guard band, a frame-start delay and one extra line. After the exit the counter returns to zero.

A small register port allows software to write and read back the control, height, limit and push registers.

Top module: `vrtc_top`

## Requirements
- R1: After reset, line_count is 0, frame_start and reg_latch are low, and every register reads back as 0.
- R2: With the enable bit (control bit 0) clear, a frame lasts VMIN+1 line ticks. VMIN is the raw value at address 2. reg_latch pulses as line_count steps to the active height (address 1), and frame_start pulses on the wrap to 0.
- R3: The addresses are: control 0, active height 1, minimum 2, maximum 3, flip line 4, push 5. The minimum, maximum and flip-line registers hold their line count minus one and read back exactly the raw value written.
- R4: Writes to addresses 1 to 4 are ignored while the enable bit is set, and accepted while it is clear.
- R5: The exit length is guard (control bits 15:8) + delay (control bits 5:4 hold delay-1) + 1. With the enable bit set and no push, the exit starts on line (VMAX+1) − exit length, and the frame lasts VMAX+1 lines.
- R6: A push posted before the earliest exit line is held. The exit then starts on line (FLIP+1) − exit length, so the frame lasts FLIP+1 lines.
- R7: A push posted while the counter sits at line n, inside the window, starts the exit on line n+1. The frame then lasts n+1+exit length lines.
- R8: The push register has an enable bit (bit 0) and a send bit (bit 1). The send bit reads 1 while a push is pending and clears when the exit starts. reg_latch pulses on the first exit line.
- R9: A push write with bit 0 clear sets no pending push and has no effect on the frame length.
- R10: With the flip-line enable (control bit 1) clear, the earliest exit line is the active height instead of the flip-line bound.
- R11: frame_start is a one-cycle pulse that follows a line tick, with line_count 0.
- R12: vblank is high exactly while line_count is at or above the active height.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst | input | 1 | Synchronous active-high reset |
| line_tick | input | 1 | One-cycle strobe at each scanline end |
| wr_en | input | 1 | Register write strobe |
| addr | input | 3 | Register address for write and read |
| wdata | input | 32 | Register write data |
| rdata | output | 32 | Register read data for addr |
| line_count | output | LINE_W | Current scanline number |
| vblank | output | 1 | Vertical blanking flag |
| frame_start | output | 1 | One-cycle pulse when the counter returns to 0 |
| reg_latch | output | 1 | One-cycle pulse when double-buffered settings latch |

## Verification
Several properties are checked on every cycle. frame_start always follows a line tick and coincides with line 0. A variable-refresh frame ends only from blanking, and every latch pulse falls inside blanking. The push send bit is already clear on the latch pulse that starts an exit. The height and minimum registers stay frozen while the enable bit is set.

Frame lengths and latch lines need the bench's scenarios to show them. These are the no-push maximum frame, a held early push, a push inside the window, a push without its enable bit, and the case where flip-line enable is off. The bench also covers readback of raw register values and the return to fixed mode.

// File: rtl/vrtc_pkg.sv
package vrtc_pkg;
    localparam int REG_W = 32;
    localparam int GB_W  = 8;
    localparam int DLY_W = 2;
    localparam int XL_W  = GB_W + 3;

    typedef enum logic [2:0] {
        A_CTRL   = 3'd0,
        A_ACTIVE = 3'd1,
        A_VMIN   = 3'd2,
        A_VMAX   = 3'd3,
        A_FLIP   = 3'd4,
        A_PUSH   = 3'd5
    } reg_addr_e;

    typedef struct packed {
        logic [GB_W-1:0]  guard;
        logic [DLY_W-1:0] dly_m1;
        logic             ign_max;
        logic             flip_en;
        logic             vrr_en;
    } ctrl_t;

    typedef struct packed {
        logic pend;
        logic en;
    } push_t;

    function automatic ctrl_t ctrl_from_word(logic [REG_W-1:0] w);
        ctrl_t c;
        c.vrr_en  = w[0];
        c.flip_en = w[1];
        c.ign_max = w[2];
        c.dly_m1  = w[5:4];
        c.guard   = w[15:8];
        return c;
    endfunction

    function automatic logic [REG_W-1:0] ctrl_to_word(ctrl_t c);
        logic [REG_W-1:0] w;
        w        = '0;
        w[0]     = c.vrr_en;
        w[1]     = c.flip_en;
        w[2]     = c.ign_max;
        w[5:4]   = c.dly_m1;
        w[15:8]  = c.guard;
        return w;
    endfunction

    // guard + (dly_m1 + 1) + 1 extra line
    function automatic logic [XL_W-1:0] exit_lines(ctrl_t c);
        return XL_W'(c.guard) + XL_W'(c.dly_m1) + XL_W'(2);
    endfunction
endpackage

// File: rtl/vrtc_regs.sv
module vrtc_regs
    import vrtc_pkg::*;
#(
    parameter int LINE_W = 12
) (
    input  logic              clk,
    input  logic              rst,
    input  logic              wr_en,
    input  logic [2:0]        addr,
    input  logic [REG_W-1:0]  wdata,
    input  logic              exit_start,
    output logic [REG_W-1:0]  rdata,
    output ctrl_t             ctrl_q,
    output logic [LINE_W-1:0] active_q,
    output logic [LINE_W-1:0] vmin_q,
    output logic [LINE_W-1:0] vmax_q,
    output logic [LINE_W-1:0] flip_q,
    output push_t             push_q
);
    logic lim_open;
    assign lim_open = !ctrl_q.vrr_en;

    always_ff @(posedge clk) begin
        if (rst) begin
            ctrl_q   <= '0;
            active_q <= '0;
            vmin_q   <= '0;
            vmax_q   <= '0;
            flip_q   <= '0;
            push_q   <= '0;
        end else begin
            if (wr_en) begin
                case (reg_addr_e'(addr))
                    A_CTRL:   ctrl_q <= ctrl_from_word(wdata);
                    A_ACTIVE: if (lim_open) active_q <= wdata[LINE_W-1:0];
                    A_VMIN:   if (lim_open) vmin_q   <= wdata[LINE_W-1:0];
                    A_VMAX:   if (lim_open) vmax_q   <= wdata[LINE_W-1:0];
                    A_FLIP:   if (lim_open) flip_q   <= wdata[LINE_W-1:0];
                    default: ;
                endcase
            end
            // a new push write takes priority over the exit-time clear
            if (wr_en && reg_addr_e'(addr) == A_PUSH) begin
                push_q.en   <= wdata[0];
                push_q.pend <= wdata[0] & wdata[1];
            end else if (exit_start) begin
                push_q.pend <= 1'b0;
            end
        end
    end

    always_comb begin
        case (reg_addr_e'(addr))
            A_CTRL:   rdata = ctrl_to_word(ctrl_q);
            A_ACTIVE: rdata = REG_W'(active_q);
            A_VMIN:   rdata = REG_W'(vmin_q);
            A_VMAX:   rdata = REG_W'(vmax_q);
            A_FLIP:   rdata = REG_W'(flip_q);
            A_PUSH:   rdata = REG_W'({push_q.pend, push_q.en});
            default:  rdata = '0;
        endcase
    end
endmodule

// File: rtl/vrtc_line.sv
module vrtc_line
    import vrtc_pkg::*;
#(
    parameter int LINE_W = 12
) (
    input  logic              clk,
    input  logic              rst,
    input  logic              line_tick,
    input  ctrl_t             ctrl,
    input  logic [LINE_W-1:0] active,
    input  logic [LINE_W-1:0] vmin_raw,
    input  logic [LINE_W-1:0] vmax_raw,
    input  logic [LINE_W-1:0] flip_raw,
    input  logic              push_live,
    output logic [LINE_W-1:0] line_cnt,
    output logic              vblank,
    output logic              frame_start,
    output logic              reg_latch,
    output logic              exit_start
);
    localparam int LW = LINE_W + 1;

    logic          exiting;
    logic [LW-1:0] end_line;
    logic [LW-1:0] nxt, xl, latest, earliest, lc_x, act_x;
    logic          blank_next;

    always_comb begin
        lc_x       = {1'b0, line_cnt};
        act_x      = {1'b0, active};
        nxt        = lc_x + LW'(1);
        xl         = LW'(exit_lines(ctrl));
        latest     = {1'b0, vmax_raw} + LW'(1) - xl;
        earliest   = ctrl.flip_en ? ({1'b0, flip_raw} + LW'(1) - xl) : act_x;
        blank_next = (nxt >= act_x);
        exit_start = line_tick && ctrl.vrr_en && !exiting && blank_next &&
                     ((push_live && nxt >= earliest) || nxt >= latest);
    end

    assign vblank = (line_cnt >= active);

    always_ff @(posedge clk) begin
        if (rst) begin
            line_cnt    <= '0;
            exiting     <= 1'b0;
            end_line    <= '0;
            frame_start <= 1'b0;
            reg_latch   <= 1'b0;
        end else begin
            frame_start <= 1'b0;
            reg_latch   <= 1'b0;
            if (!ctrl.vrr_en) exiting <= 1'b0;
            if (line_tick) begin
                if (!ctrl.vrr_en) begin
                    if (line_cnt >= vmin_raw) begin
                        line_cnt    <= '0;
                        frame_start <= 1'b1;
                    end else begin
                        line_cnt  <= nxt[LINE_W-1:0];
                        reg_latch <= (nxt == act_x);
                    end
                end else if (exiting) begin
                    if (lc_x >= end_line) begin
                        line_cnt    <= '0;
                        frame_start <= 1'b1;
                        exiting     <= 1'b0;
                    end else begin
                        line_cnt <= nxt[LINE_W-1:0];
                    end
                end else begin
                    line_cnt <= nxt[LINE_W-1:0];
                    if (exit_start) begin
                        exiting   <= 1'b1;
                        end_line  <= nxt + xl - LW'(1);
                        reg_latch <= 1'b1;
                    end
                end
            end
        end
    end
endmodule

// File: rtl/vrtc_top.sv
module vrtc_top
    import vrtc_pkg::*;
#(
    parameter int LINE_W = 12
) (
    input  logic              clk,
    input  logic              rst,
    input  logic              line_tick,
    input  logic              wr_en,
    input  logic [2:0]        addr,
    input  logic [31:0]       wdata,
    output logic [31:0]       rdata,
    output logic [LINE_W-1:0] line_count,
    output logic              vblank,
    output logic              frame_start,
    output logic              reg_latch
);
    ctrl_t             ctrl_q;
    push_t             push_q;
    logic [LINE_W-1:0] active_q, vmin_q, vmax_q, flip_q;
    logic              exit_start;

    vrtc_regs #(.LINE_W(LINE_W)) u_regs (
        .clk(clk), .rst(rst), .wr_en(wr_en), .addr(addr), .wdata(wdata),
        .exit_start(exit_start), .rdata(rdata), .ctrl_q(ctrl_q),
        .active_q(active_q), .vmin_q(vmin_q), .vmax_q(vmax_q),
        .flip_q(flip_q), .push_q(push_q)
    );

    vrtc_line #(.LINE_W(LINE_W)) u_line (
        .clk(clk), .rst(rst), .line_tick(line_tick), .ctrl(ctrl_q),
        .active(active_q), .vmin_raw(vmin_q), .vmax_raw(vmax_q),
        .flip_raw(flip_q), .push_live(push_q.pend & push_q.en),
        .line_cnt(line_count), .vblank(vblank), .frame_start(frame_start),
        .reg_latch(reg_latch), .exit_start(exit_start)
    );
endmodule

// File: rtl/vrtc_chk.sv
module vrtc_chk #(
    parameter int LINE_W = 12
) (
    input logic              clk,
    input logic              rst,
    input logic              line_tick,
    input logic              wr_en,
    input logic              frame_start,
    input logic              reg_latch,
    input logic              vblank,
    input logic [LINE_W-1:0] line_count,
    input logic              vrr_en,
    input logic              push_pend,
    input logic [LINE_W-1:0] vmin_q,
    input logic [LINE_W-1:0] active_q
);
    a_r11_fs_after_tick: assert property (@(posedge clk) disable iff (rst)
        frame_start |-> $past(line_tick));

    a_r11_fs_line_zero: assert property (@(posedge clk) disable iff (rst)
        frame_start |-> line_count == '0);

    a_r8_push_cleared: assert property (@(posedge clk) disable iff (rst)
        (reg_latch && vrr_en && $past(vrr_en) && !$past(wr_en)) |-> !push_pend);

    a_r4_limits_locked: assert property (@(posedge clk) disable iff (rst)
        (vrr_en && $past(vrr_en)) |-> ($stable(vmin_q) && $stable(active_q)));

    a_r12_latch_in_blank: assert property (@(posedge clk) disable iff (rst)
        (reg_latch && !$past(wr_en)) |-> vblank);

    a_r5_frame_ends_in_blank: assert property (@(posedge clk) disable iff (rst)
        (frame_start && vrr_en && $past(vrr_en)) |-> $past(vblank));
endmodule

bind vrtc_top vrtc_chk #(.LINE_W(LINE_W)) u_chk (
    .clk(clk), .rst(rst), .line_tick(line_tick), .wr_en(wr_en),
    .frame_start(frame_start), .reg_latch(reg_latch), .vblank(vblank),
    .line_count(line_count), .vrr_en(ctrl_q.vrr_en), .push_pend(push_q.pend),
    .vmin_q(vmin_q), .active_q(active_q)
);

// File: tb/tb_vrtc_top.sv
module tb_vrtc_top;
    localparam int CLK_P  = 10;
    localparam int LINE_W = 12;

    typedef struct {
        int    len;
        int    latch;
        string req;
    } exp_t;

    logic              clk = 0;
    logic              rst = 1;
    logic              line_tick = 0;
    logic              wr_en = 0;
    logic [2:0]        addr = 0;
    logic [31:0]       wdata = 0;
    logic [31:0]       rdata;
    logic [LINE_W-1:0] line_count;
    logic              vblank, frame_start, reg_latch;

    int   n_chk = 0, n_fail = 0;
    int   tick_cnt = 0, latch_seen = -1, fs_cnt = 0;
    bit   sb_on = 0;
    exp_t sb_q[$];

    vrtc_top #(.LINE_W(LINE_W)) dut (
        .clk(clk), .rst(rst), .line_tick(line_tick), .wr_en(wr_en),
        .addr(addr), .wdata(wdata), .rdata(rdata), .line_count(line_count),
        .vblank(vblank), .frame_start(frame_start), .reg_latch(reg_latch)
    );

    always #(CLK_P/2) clk = ~clk;

    task automatic chk(bit ok, string req, int act, int exp);
        n_chk++;
        if (!ok) begin
            n_fail++;
            $display("FAIL %s actual=%0d expected=%0d", req, act, exp);
        end
    endtask

    task automatic wr(logic [2:0] a, logic [31:0] d);
        @(posedge clk); #1;
        wr_en = 1; addr = a; wdata = d;
        @(posedge clk); #1;
        wr_en = 0;
    endtask

    task automatic rd_chk(logic [2:0] a, int exp, string req);
        @(negedge clk);
        addr = a;
        #1;
        chk(rdata == 32'(exp), req, int'(rdata), exp);
    endtask

    task automatic tick();
        @(posedge clk); #1;
        line_tick = 1;
        @(posedge clk); #1;
        line_tick = 0;
        @(negedge clk); #1;
    endtask

    // monitor: measure frame length and latch line, compare with scoreboard
    always @(negedge clk) begin
        if (line_tick) tick_cnt++;
        if (reg_latch) latch_seen = int'(line_count);
        if (frame_start) begin
            if (sb_on) begin
                if (sb_q.size() == 0) begin
                    chk(0, "R11 unexpected frame", tick_cnt, 0);
                end else begin
                    exp_t e;
                    e = sb_q.pop_front();
                    chk(tick_cnt == e.len, {e.req, " frame length"}, tick_cnt, e.len);
                    chk(latch_seen == e.latch, {e.req, " latch line"}, latch_seen, e.latch);
                end
                chk(line_count == 0, "R11 frame_start at line 0", int'(line_count), 0);
            end
            tick_cnt   = 0;
            latch_seen = -1;
            fs_cnt++;
        end
    end

    task automatic run_frame(int push_at, logic [31:0] push_val, int push_rd,
                             int len, int latch, string req);
        int start;
        exp_t e;
        e.len = len; e.latch = latch; e.req = req;
        sb_q.push_back(e);
        start = fs_cnt;
        while (fs_cnt == start) begin
            if (int'(line_count) == push_at) begin
                wr(3'd5, push_val);
                rd_chk(3'd5, push_rd, "R8 push pending readback");
            end
            if (line_count == 0)  chk(vblank == 0, "R12 vblank low in active", int'(vblank), 0);
            if (line_count == 10) chk(vblank == 1, "R12 vblank high in blank", int'(vblank), 1);
            tick();
        end
    endtask

    initial begin
        #(CLK_P * 200000);
        n_fail++;
        $display("FAIL watchdog expired actual=%0d expected=%0d", n_chk, 0);
        $display("%0d/%0d checks passed", n_chk + 1 - n_fail, n_chk + 1);
        $finish;
    end

    initial begin
        repeat (3) @(posedge clk);
        #1 rst = 0;
        @(negedge clk);
        chk(line_count == 0, "R1 line_count", int'(line_count), 0);
        chk(frame_start == 0, "R1 frame_start", int'(frame_start), 0);
        chk(reg_latch == 0, "R1 reg_latch", int'(reg_latch), 0);
        rd_chk(3'd0, 0, "R1 ctrl reset");
        rd_chk(3'd2, 0, "R1 vmin reset");
        rd_chk(3'd5, 0, "R1 push reset");

        // active 10, vmin 20, flip 21, vmax 40 lines; guard 2, delay 1 -> exit 4
        wr(3'd1, 10);
        wr(3'd2, 19);
        wr(3'd4, 20);
        wr(3'd3, 39);
        wr(3'd0, 32'h202);
        rd_chk(3'd2, 19, "R3 vmin raw");
        rd_chk(3'd4, 20, "R3 flip raw");
        rd_chk(3'd3, 39, "R3 vmax raw");
        rd_chk(3'd0, 32'h202, "R3 ctrl readback");

        begin
            int s;
            s = fs_cnt;
            while (fs_cnt == s) tick();
        end
        sb_on = 1;

        run_frame(-1, 0, 0, 20, 10, "R2 fixed");
        run_frame(-1, 0, 0, 20, 10, "R2 fixed");

        wr(3'd0, 32'h203);
        run_frame(-1, 0, 0, 40, 36, "R5 no push");

        wr(3'd2, 5);
        wr(3'd1, 3);
        rd_chk(3'd2, 19, "R4 vmin locked");
        rd_chk(3'd1, 10, "R4 active locked");

        run_frame(0, 3, 3, 21, 17, "R6 early push");
        rd_chk(3'd5, 1, "R8 send cleared");
        run_frame(25, 3, 3, 30, 26, "R7 window push");
        rd_chk(3'd5, 1, "R8 send cleared");
        run_frame(0, 2, 0, 40, 36, "R9 push without enable");

        wr(3'd0, 32'h201);
        run_frame(0, 3, 3, 14, 10, "R10 flip off");

        wr(3'd0, 0);
        wr(3'd5, 0);
        rd_chk(3'd0, 0, "R4 ctrl disabled");
        wr(3'd2, 29);
        rd_chk(3'd2, 29, "R4 vmin accepted");
        run_frame(-1, 0, 0, 30, 10, "R2 fixed after disable");

        chk(sb_q.size() == 0, "R11 scoreboard drained", sb_q.size(), 0);
        $display("%0d/%0d checks passed", n_chk - n_fail, n_chk);
        $finish;
    end
endmodule